// File: doc/BRIEF.md
# Cache Snoop and Invalidation Controller

This block keeps the tag, valid and dirty state of a four-way write-back data cache consistent with memory that other bus masters access. An external agent presents a line address and a one-bit kind selector. The block searches the addressed set, reports one cycle later whether the line is present and whether it is dirty, and then acts. A dirty line that another master is about to read must first be written back to memory. A line that another master is about to overwrite is dropped. A dirty line that another master is about to overwrite is written back first and then dropped.

Each action ends with a special bus cycle. The block drives a small coded address that names the cycle kind and holds it until either of two ready acknowledges arrives. A fill port installs lines, and a flush input discards every line at once and announces this with its own special cycle. The data arrays, burst transfers and bus arbitration are outside this block. The write-back is only requested here, and a separate acknowledge reports when it is done.

Top module: `snoop_inval_ctl`

## Requirements
- R1: After reset `busy`, `wb_req`, `spc_valid` and `snp_rsp` are 0 and every line is invalid, so any snoop misses.
- R2: A snoop is accepted when `snp_valid` is 1 and `busy` is 0. One cycle later `snp_rsp` pulses for one cycle. `snp_hit` is then 1 if a valid way of set `snp_line[IDX_W-1:0]` holds tag `snp_line[LINE_W-1:IDX_W]`. `snp_hitm` is 1 if that line is also dirty.
- R3: A fill writes the tag of `fill_line` into way `fill_way` of its set, sets that way valid, and sets its dirty bit to `fill_dirty`. Ways of one set are independent. A fill is applied only in a cycle where `busy` is 0 and neither `snp_valid` nor `flush_req` is 1. Otherwise it is dropped.
- R4: A miss of either kind, or a clean hit with `snp_inv`=0, starts no bus activity. `busy` stays 0 and the line state is unchanged.
- R5: A dirty hit of either kind raises `wb_req` in the same cycle as `snp_rsp`, with `wb_line` equal to the snooped line address. Both are held unchanged until `wb_ack` is sampled high.
- R6: For `snp_inv`=0 with a dirty hit, the write-back acknowledge leaves the line valid and clears its dirty bit. A write-back special cycle follows.
- R7: For `snp_inv`=1 with a hit, the line becomes invalid and clean. A clean hit is cleared at once, and a dirty hit is cleared when `wb_ack` arrives. An invalidate special cycle follows in both cases. An invalidate miss starts no special cycle.
- R8: During a special cycle `spc_valid` is 1 and `spc_kind` is 1 (write-back), 2 (flush) or 3 (invalidate). `spc_addr` equals `spc_kind` shifted left by two bits and zero-extended. These values hold until `rdy` or `brdy` is sampled high, and the cycle ends at that edge.
- R9: While `busy` is 1 a snoop is ignored. No `snp_rsp` is produced and the line state is unchanged.
- R10: `flush_req`, when `busy` is 0 and `snp_valid` is 0, makes every line invalid and clean and starts a flush special cycle. If a snoop is presented in the same cycle, the snoop wins and the flush request is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | Snoop strobe |
| snp_line | input | LINE_W | Snooped line address: index in the low bits, tag above |
| snp_inv | input | 1 | 0 inquire (other master reads), 1 invalidate (other master writes) |
| fill_en | input | 1 | Install a line |
| fill_line | input | LINE_W | Line address to install |
| fill_way | input | WAY_W | Way that receives the line |
| fill_dirty | input | 1 | Dirty state of the installed line |
| flush_req | input | 1 | Discard all lines |
| wb_ack | input | 1 | Write-back completed |
| rdy | input | 1 | Single-transfer ready for a special cycle |
| brdy | input | 1 | Burst ready for a special cycle |
| busy | output | 1 | Write-back or special cycle pending |
| snp_rsp | output | 1 | Snoop result strobe |
| snp_hit | output | 1 | Snooped line present |
| snp_hitm | output | 1 | Snooped line present and dirty |
| wb_req | output | 1 | Write-back request |
| wb_line | output | LINE_W | Line to write back |
| spc_valid | output | 1 | Special cycle active |
| spc_kind | output | 2 | Special cycle kind code |
| spc_addr | output | AW | Coded address driven during the special cycle |

## Verification
A corrupted valid or dirty bit shows up on the next snoop to that line. It appears one cycle after the strobe, as a wrong `snp_hit` or `snp_hitm` value or as a `wb_req` that is wrongly present or missing. A wrong sequencing state shows sooner. An early exit drops `wb_req` or `spc_valid` before the acknowledge, and a missed exit leaves `busy` high, so the next snoop produces no response. Each action is therefore followed by a re-snoop of the same line and of a neighbouring way, and that re-snoop brings the stored state out through the normal result pins.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    SPC_NONE  = 2'd0,
    SPC_WB    = 2'd1,
    SPC_FLUSH = 2'd2,
    SPC_INV   = 2'd3
  } spc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_SPC  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/snp_tag_store.sv
module snp_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8,
  parameter int WAYS  = 4,
  localparam int SETS   = 1 << IDX_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] lk_line,
  output logic              lk_hit,
  output logic              lk_mod,
  output logic [WAY_W-1:0]  lk_way,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic              fill_dirty,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_set,
  input  logic [WAY_W-1:0]  upd_way,
  input  logic              upd_clr_valid,
  input  logic              flush_en
);
  logic [TAG_W-1:0] tag_mem [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  mod_q [SETS];
  logic [WAYS-1:0]  match;

  logic [IDX_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [IDX_W-1:0] fill_set;
  logic [TAG_W-1:0] fill_tag;

  assign lk_set   = lk_line[IDX_W-1:0];
  assign lk_tag   = lk_line[LINE_W-1:IDX_W];
  assign fill_set = fill_line[IDX_W-1:0];
  assign fill_tag = fill_line[LINE_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_q[lk_set][w] && (tag_mem[lk_set][w] == lk_tag);
  end

  always_comb begin
    lk_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) lk_way = WAY_W'(w);
    end
  end

  assign lk_hit = |match;
  assign lk_mod = lk_hit && mod_q[lk_set][lk_way];

  // Tag storage: plain write port, no reset
  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_set][fill_way] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (rst || flush_en) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        mod_q[s] <= '0;
      end
    end else begin
      if (upd_en) begin
        mod_q[upd_set][upd_way] <= 1'b0;
        if (upd_clr_valid) vld_q[upd_set][upd_way] <= 1'b0;
      end
      if (fill_en) begin
        vld_q[fill_set][fill_way] <= 1'b1;
        mod_q[fill_set][fill_way] <= fill_dirty;
      end
    end
  end

  // R3
  fill_excl_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> !(upd_en || flush_en));

  for (genvar s = 0; s < SETS; s++) begin : g_state_chk
    // R7
    dirty_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (mod_q[s] & ~vld_q[s]) == '0);
  end
endmodule

// File: rtl/snp_ctrl.sv
module snp_ctrl
  import snp_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 8,
  parameter int WAYS  = 4,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [LINE_W-1:0] snp_line,
  input  logic              snp_inv,
  input  logic              lk_hit,
  input  logic              lk_mod,
  input  logic [WAY_W-1:0]  lk_way,
  input  logic              flush_req,
  input  logic              fill_req,
  input  logic              wb_ack,
  input  logic              rdy,
  input  logic              brdy,
  output logic              busy,
  output logic              snp_rsp,
  output logic              snp_hit,
  output logic              snp_hitm,
  output logic              wb_req,
  output logic [LINE_W-1:0] wb_line,
  output logic              spc_valid,
  output logic [1:0]        spc_kind,
  output logic [AW-1:0]     spc_addr,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_set,
  output logic [WAY_W-1:0]  upd_way,
  output logic              upd_clr_valid,
  output logic              flush_en,
  output logic              fill_go
);
  ctl_state_e       state_q;
  spc_kind_e        kind_q;
  logic             rsp_q, hit_q, hitm_q, inv_q;
  logic [WAY_W-1:0] way_q;
  logic [LINE_W-1:0] line_q;

  logic idle, accept, clean_inv, wb_done, spc_done;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle && snp_valid;
  assign flush_en  = idle && !snp_valid && flush_req;
  assign fill_go   = idle && !snp_valid && !flush_req && fill_req;
  assign clean_inv = accept && snp_inv && lk_hit && !lk_mod;
  assign wb_done   = (state_q == ST_WB) && wb_ack;
  assign spc_done  = (state_q == ST_SPC) && (rdy || brdy);

  // Array update: immediate for clean invalidate, deferred for write-back
  assign upd_en        = clean_inv || wb_done;
  assign upd_set       = wb_done ? line_q[IDX_W-1:0] : snp_line[IDX_W-1:0];
  assign upd_way       = wb_done ? way_q : lk_way;
  assign upd_clr_valid = wb_done ? inv_q : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      kind_q  <= SPC_NONE;
      rsp_q   <= 1'b0;
      hit_q   <= 1'b0;
      hitm_q  <= 1'b0;
      inv_q   <= 1'b0;
      way_q   <= '0;
      line_q  <= '0;
    end else begin
      rsp_q <= accept;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            hit_q  <= lk_hit;
            hitm_q <= lk_mod;
            inv_q  <= snp_inv;
            way_q  <= lk_way;
            line_q <= snp_line;
            if (lk_mod) begin
              state_q <= ST_WB;
            end else if (clean_inv) begin
              state_q <= ST_SPC;
              kind_q  <= SPC_INV;
            end
          end else if (flush_en) begin
            state_q <= ST_SPC;
            kind_q  <= SPC_FLUSH;
          end
        end
        ST_WB: begin
          if (wb_ack) begin
            state_q <= ST_SPC;
            kind_q  <= inv_q ? SPC_INV : SPC_WB;
          end
        end
        ST_SPC: begin
          if (spc_done) begin
            state_q <= ST_IDLE;
            kind_q  <= SPC_NONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = !idle;
  assign snp_rsp   = rsp_q;
  assign snp_hit   = hit_q;
  assign snp_hitm  = hitm_q;
  assign wb_req    = (state_q == ST_WB);
  assign wb_line   = line_q;
  assign spc_valid = (state_q == ST_SPC);
  assign spc_kind  = kind_q;
  assign spc_addr  = {{(AW-4){1'b0}}, kind_q, 2'b00};

  // R5
  wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_line)));

  // R5
  wb_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_req) |-> (snp_rsp && snp_hitm));

  // R8
  spc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (spc_valid && !(rdy || brdy)) |=> (spc_valid && $stable(spc_addr)));

  // R9
  rsp_accept_chk: assert property (@(posedge clk) disable iff (rst)
    snp_rsp |-> ($past(snp_valid) && !$past(busy)));

  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_rsp && !snp_hit) |-> !busy);
endmodule

// File: rtl/snoop_inval_ctl.sv
module snoop_inval_ctl #(
  parameter int AW    = 16,
  parameter int OFF_W = 4,
  parameter int IDX_W = 4,
  parameter int WAYS  = 4,
  localparam int TAG_W  = AW - OFF_W - IDX_W,
  localparam int LINE_W = AW - OFF_W,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [LINE_W-1:0] snp_line,
  input  logic              snp_inv,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic              fill_dirty,
  input  logic              flush_req,
  input  logic              wb_ack,
  input  logic              rdy,
  input  logic              brdy,
  output logic              busy,
  output logic              snp_rsp,
  output logic              snp_hit,
  output logic              snp_hitm,
  output logic              wb_req,
  output logic [LINE_W-1:0] wb_line,
  output logic              spc_valid,
  output logic [1:0]        spc_kind,
  output logic [AW-1:0]     spc_addr
);
  logic             lk_hit, lk_mod;
  logic [WAY_W-1:0] lk_way;
  logic             upd_en, upd_clr_valid, flush_en, fill_go;
  logic [IDX_W-1:0] upd_set;
  logic [WAY_W-1:0] upd_way;

  snp_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WAYS(WAYS)) u_store (
    .clk           (clk),
    .rst           (rst),
    .lk_line       (snp_line),
    .lk_hit        (lk_hit),
    .lk_mod        (lk_mod),
    .lk_way        (lk_way),
    .fill_en       (fill_go),
    .fill_line     (fill_line),
    .fill_way      (fill_way),
    .fill_dirty    (fill_dirty),
    .upd_en        (upd_en),
    .upd_set       (upd_set),
    .upd_way       (upd_way),
    .upd_clr_valid (upd_clr_valid),
    .flush_en      (flush_en)
  );

  snp_ctrl #(.AW(AW), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAYS(WAYS)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .snp_valid     (snp_valid),
    .snp_line      (snp_line),
    .snp_inv       (snp_inv),
    .lk_hit        (lk_hit),
    .lk_mod        (lk_mod),
    .lk_way        (lk_way),
    .flush_req     (flush_req),
    .fill_req      (fill_en),
    .wb_ack        (wb_ack),
    .rdy           (rdy),
    .brdy          (brdy),
    .busy          (busy),
    .snp_rsp       (snp_rsp),
    .snp_hit       (snp_hit),
    .snp_hitm      (snp_hitm),
    .wb_req        (wb_req),
    .wb_line       (wb_line),
    .spc_valid     (spc_valid),
    .spc_kind      (spc_kind),
    .spc_addr      (spc_addr),
    .upd_en        (upd_en),
    .upd_set       (upd_set),
    .upd_way       (upd_way),
    .upd_clr_valid (upd_clr_valid),
    .flush_en      (flush_en),
    .fill_go       (fill_go)
  );
endmodule

// File: tb/snoop_inval_ctl_tb.sv
module snoop_inval_ctl_tb;
  localparam int AW = 16;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic snp_valid = 1'b0, snp_inv = 1'b0;
  logic [LW-1:0] snp_line = '0;
  logic fill_en = 1'b0, fill_dirty = 1'b0;
  logic [LW-1:0] fill_line = '0;
  logic [1:0] fill_way = '0;
  logic flush_req = 1'b0, wb_ack = 1'b0, rdy = 1'b0, brdy = 1'b0;
  logic busy, snp_rsp, snp_hit, snp_hitm, wb_req, spc_valid;
  logic [LW-1:0] wb_line;
  logic [1:0] spc_kind;
  logic [AW-1:0] spc_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  snoop_inval_ctl u_dut (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_line(snp_line),
    .snp_inv(snp_inv), .fill_en(fill_en), .fill_line(fill_line),
    .fill_way(fill_way), .fill_dirty(fill_dirty), .flush_req(flush_req),
    .wb_ack(wb_ack), .rdy(rdy), .brdy(brdy), .busy(busy),
    .snp_rsp(snp_rsp), .snp_hit(snp_hit), .snp_hitm(snp_hitm),
    .wb_req(wb_req), .wb_line(wb_line), .spc_valid(spc_valid),
    .spc_kind(spc_kind), .spc_addr(spc_addr)
  );

  function automatic logic [LW-1:0] ln(input logic [7:0] tag, input logic [3:0] idx);
    return {tag, idx};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic snoop(input logic [LW-1:0] l, input logic inv);
    snp_line = l; snp_inv = inv; snp_valid = 1'b1;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic fill(input logic [LW-1:0] l, input logic [1:0] w, input logic d);
    fill_line = l; fill_way = w; fill_dirty = d; fill_en = 1'b1;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic ack_wb();
    wb_ack = 1'b1;
    @(negedge clk);
    wb_ack = 1'b0;
  endtask

  task automatic ack_spc(input bit use_burst);
    if (use_burst) brdy = 1'b1; else rdy = 1'b1;
    @(negedge clk);
    brdy = 1'b0; rdy = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [LW-1:0] l,
                            input logic h, input logic hm);
    snoop(l, 1'b0);
    chk(req, "rsp", snp_rsp, 1);
    chk(req, "hit", snp_hit, h);
    chk(req, "hitm", snp_hitm, hm);
    if (hm) begin
      ack_wb();
      ack_spc(1'b0);
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "wb_req", wb_req, 0);
    chk("R1", "spc_valid", spc_valid, 0);
    chk("R1", "snp_rsp", snp_rsp, 0);
    snoop(ln(8'h11, 4'h2), 1'b0);
    chk("R1", "hit after reset", snp_hit, 0);
  endtask

  task automatic t_inquire_clean();
    fill(ln(8'h11, 4'h2), 2'd0, 1'b0);
    fill(ln(8'h22, 4'h2), 2'd1, 1'b1);
    fill(ln(8'h33, 4'h5), 2'd3, 1'b0);
    snoop(ln(8'h11, 4'h2), 1'b0);
    chk("R2", "rsp", snp_rsp, 1);
    chk("R2", "hit", snp_hit, 1);
    chk("R2", "hitm", snp_hitm, 0);
    chk("R4", "busy clean inquire", busy, 0);
    chk("R4", "wb_req clean inquire", wb_req, 0);
    @(negedge clk);
    chk("R2", "rsp single pulse", snp_rsp, 0);
    snoop(ln(8'h44, 4'h2), 1'b0);
    chk("R2", "tag mismatch hit", snp_hit, 0);
    chk("R4", "miss busy", busy, 0);
    snoop(ln(8'h33, 4'h5), 1'b0);
    chk("R3", "way3 hit", snp_hit, 1);
  endtask

  task automatic t_inquire_dirty();
    snoop(ln(8'h22, 4'h2), 1'b0);
    chk("R5", "hitm", snp_hitm, 1);
    chk("R5", "wb_req", wb_req, 1);
    chk("R5", "wb_line", wb_line, ln(8'h22, 4'h2));
    chk("R5", "busy", busy, 1);
    snoop(ln(8'h11, 4'h2), 1'b1);
    chk("R9", "rsp while busy", snp_rsp, 0);
    repeat (2) @(negedge clk);
    chk("R5", "wb_req held", wb_req, 1);
    chk("R5", "wb_line held", wb_line, ln(8'h22, 4'h2));
    ack_wb();
    chk("R6", "wb_req dropped", wb_req, 0);
    chk("R8", "spc_valid", spc_valid, 1);
    chk("R6", "spc_kind wb", spc_kind, 1);
    chk("R8", "spc_addr wb", spc_addr, 16'h0004);
    repeat (2) @(negedge clk);
    chk("R8", "spc held", spc_valid, 1);
    chk("R8", "spc_addr held", spc_addr, 16'h0004);
    ack_spc(1'b0);
    chk("R8", "spc ended", spc_valid, 0);
    chk("R8", "busy ended", busy, 0);
    expect_hit("R6", ln(8'h22, 4'h2), 1'b1, 1'b0);
    expect_hit("R9", ln(8'h11, 4'h2), 1'b1, 1'b0);
  endtask

  task automatic t_inval_clean();
    snoop(ln(8'h11, 4'h2), 1'b1);
    chk("R7", "hit", snp_hit, 1);
    chk("R7", "wb_req clean inv", wb_req, 0);
    chk("R7", "spc_valid", spc_valid, 1);
    chk("R7", "spc_kind inv", spc_kind, 3);
    chk("R8", "spc_addr inv", spc_addr, 16'h000C);
    ack_spc(1'b1);
    chk("R8", "brdy ends", busy, 0);
    expect_hit("R7", ln(8'h11, 4'h2), 1'b0, 1'b0);
    expect_hit("R3", ln(8'h22, 4'h2), 1'b1, 1'b0);
  endtask

  task automatic t_inval_dirty();
    fill(ln(8'h55, 4'h9), 2'd2, 1'b1);
    snoop(ln(8'h55, 4'h9), 1'b1);
    chk("R7", "hitm", snp_hitm, 1);
    chk("R5", "wb_req inv", wb_req, 1);
    chk("R7", "no spc before ack", spc_valid, 0);
    ack_wb();
    chk("R7", "spc_kind inv", spc_kind, 3);
    ack_spc(1'b1);
    expect_hit("R7", ln(8'h55, 4'h9), 1'b0, 1'b0);
    snoop(ln(8'h66, 4'h9), 1'b1);
    chk("R7", "inv miss hit", snp_hit, 0);
    chk("R7", "inv miss spc", spc_valid, 0);
    chk("R7", "inv miss busy", busy, 0);
  endtask

  task automatic t_fill_blocked();
    fill_line = ln(8'h77, 4'h6); fill_way = 2'd0; fill_dirty = 1'b0; fill_en = 1'b1;
    snoop(ln(8'h78, 4'h6), 1'b0);
    fill_en = 1'b0;
    expect_hit("R3", ln(8'h77, 4'h6), 1'b0, 1'b0);
  endtask

  task automatic t_flush();
    fill(ln(8'h88, 4'hA), 2'd1, 1'b1);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    chk("R10", "spc_valid", spc_valid, 1);
    chk("R10", "spc_kind flush", spc_kind, 2);
    chk("R8", "spc_addr flush", spc_addr, 16'h0008);
    ack_spc(1'b0);
    expect_hit("R10", ln(8'h88, 4'hA), 1'b0, 1'b0);
    expect_hit("R10", ln(8'h22, 4'h2), 1'b0, 1'b0);
    fill(ln(8'h99, 4'h3), 2'd0, 1'b0);
    flush_req = 1'b1;
    snoop(ln(8'h99, 4'h3), 1'b0);
    flush_req = 1'b0;
    chk("R10", "snoop wins hit", snp_hit, 1);
    chk("R10", "no flush cycle", spc_valid, 0);
    expect_hit("R10", ln(8'h99, 4'h3), 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_inquire_clean();
    t_inquire_dirty();
    t_inval_clean();
    t_inval_dirty();
    t_fill_blocked();
    t_flush();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule